// File: doc/BRIEF.md
# Multi-bank RAM zero-fill and protection-bypass controller

This block sits in front of several local RAM banks whose words carry one protection bit each. A single 32-bit control word holds two bits per bank. One bit starts a hardware sweep that writes zero to every location of the bank. The other switches the bank into a raw test mode. During a sweep, each location is written with a check bit that matches both its zero data and its own address. After the sweep, a later read of an untouched location therefore shows no protection error.

Each bank has its own sweep sequencer, and the sequencers run independently. A sweep writes one location per clock, in ascending order. The bank shows busy for the whole sweep and gives a one-cycle done pulse when it finishes. Normal write traffic to a bank that is sweeping is stalled, because the sweep owns the RAM port. When the bank is idle, normal writes pass through, and their check bit is generated from the data and the address. In test mode, generation is bypassed and the caller's raw check bit is written unchanged, so software can plant known-bad words.

The check bit is a stand-in for a real code: even parity of the data word XOR parity of the address.

Top module: `ramfill_ctrl`

## Requirements
- R1: After reset the control word reads 0, no bank is busy, no done pulse is raised and no RAM write enable is active.
- R2: Control word bits 31 to 8 always read as 0, whatever was written.
- R3: Bit 2n+1 of the control word is the test-mode enable of bank n. It takes the written value on every control write and holds it until the next write.
- R4: Bit 2n of the control word is the fill trigger of bank n and always reads as 0.
- R5: A control write with bit 2n at 1 while bank n is idle starts a sweep from the next cycle. The sweep writes addresses 0 to DEPTH-1 in ascending order, one per clock, with data 0 and check bit equal to the XOR of the address bits. A write with bit 2n at 0 starts nothing.
- R6: The busy flag of a bank is high for exactly DEPTH cycles per sweep. The done flag is high for one cycle, the cycle right after the last sweep write.
- R7: A trigger written while the bank is busy is ignored, and the running sweep continues at its current address.
- R8: Sweeps of different banks run concurrently and do not affect one another.
- R9: While a bank is idle and not in test mode, a normal request writes the given address and data, with check bit equal to (XOR of data bits) XOR (XOR of address bits).
- R10: While a bank is idle and in test mode, a normal request writes the caller's raw check bit unchanged.
- R11: While a bank is busy, a normal request to it is stalled (stall equals request) and the RAM port carries the sweep write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read value |
| acc_req | input | NUM_BANKS | Normal write request per bank |
| acc_addr | input | NUM_BANKS*ADDR_W | Normal write address per bank |
| acc_wdata | input | NUM_BANKS*DATA_W | Normal write data per bank |
| acc_wcheck | input | NUM_BANKS | Raw check bit used in test mode |
| acc_stall | output | NUM_BANKS | Request held off by a running sweep |
| ram_we | output | NUM_BANKS | RAM write enable per bank |
| ram_addr | output | NUM_BANKS*ADDR_W | RAM write address per bank |
| ram_data | output | NUM_BANKS*DATA_W | RAM write data per bank |
| ram_check | output | NUM_BANKS | RAM check bit per bank |
| busy | output | NUM_BANKS | Sweep running per bank |
| done | output | NUM_BANKS | One-cycle sweep completion pulse |

## Verification
The bench builds the block with four banks of 16 words of 32 bits. With that depth a whole sweep lasts only 16 cycles, so the run can fit several full sweeps, a trigger written in the middle of a sweep, and sweeps that overlap across banks. A 4-bit address also makes the address parity in the check bit take both values many times over every sweep.

// File: rtl/ramfill_pkg.sv
package ramfill_pkg;

  function automatic logic word_parity(input logic [63:0] v);
    return ^v;
  endfunction

endpackage

// File: rtl/ramfill_rst_sync.sv
module ramfill_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/ramfill_regs.sv
module ramfill_regs #(
  parameter int NUM_BANKS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  output logic [NUM_BANKS-1:0] start,
  output logic [NUM_BANKS-1:0] test_en
);
  logic [NUM_BANKS-1:0] test_q, test_d;

  always_comb begin
    test_d = test_q;
    rdata  = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      start[b] = wr_en & wdata[2*b];
      if (wr_en) test_d[b] = wdata[2*b+1];
      rdata[2*b+1] = test_q[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     test_q <= '0;
    else if (wr_en) test_q <= test_d;
  end

  assign test_en = test_q;
endmodule

// File: rtl/ramfill_seq.sv
module ramfill_seq #(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic [ADDR_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (busy_q) begin
      cnt_en = 1'b1;
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (start) begin
      busy_d = 1'b1;
      cnt_en = 1'b1;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = busy_q;
  assign done = done_q;
  assign addr = cnt_q;
endmodule

// File: rtl/ramfill_port.sv
module ramfill_port #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              fill_busy,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              test_en,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              req_check,
  output logic              stall,
  output logic              we,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data,
  output logic              check
);
  import ramfill_pkg::*;

  always_comb begin
    stall = req & fill_busy;
    if (fill_busy) begin
      we    = 1'b1;
      addr  = fill_addr;
      data  = '0;
      check = word_parity(64'(fill_addr));
    end else begin
      we    = req;
      addr  = req_addr;
      data  = req_data;
      check = test_en ? req_check
                      : (word_parity(64'(req_data)) ^ word_parity(64'(req_addr)));
    end
  end
endmodule

// File: rtl/ramfill_ctrl.sv
module ramfill_ctrl #(
  parameter int NUM_BANKS = 4,
  parameter int DEPTH     = 64,
  parameter int DATA_W    = 32,
  localparam int ADDR_W   = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_wr,
  input  logic [31:0]                   reg_wdata,
  output logic [31:0]                   reg_rdata,
  input  logic [NUM_BANKS-1:0]          acc_req,
  input  logic [NUM_BANKS*ADDR_W-1:0]   acc_addr,
  input  logic [NUM_BANKS*DATA_W-1:0]   acc_wdata,
  input  logic [NUM_BANKS-1:0]          acc_wcheck,
  output logic [NUM_BANKS-1:0]          acc_stall,
  output logic [NUM_BANKS-1:0]          ram_we,
  output logic [NUM_BANKS*ADDR_W-1:0]   ram_addr,
  output logic [NUM_BANKS*DATA_W-1:0]   ram_data,
  output logic [NUM_BANKS-1:0]          ram_check,
  output logic [NUM_BANKS-1:0]          busy,
  output logic [NUM_BANKS-1:0]          done
);
  logic                 rst_n_int;
  logic [NUM_BANKS-1:0] start;
  logic [NUM_BANKS-1:0] test_en;

  ramfill_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  ramfill_regs #(.NUM_BANKS(NUM_BANKS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_en   (reg_wr),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .start   (start),
    .test_en (test_en)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [ADDR_W-1:0] fill_addr;

    ramfill_seq #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_seq (
      .clk   (clk),
      .rst_n (rst_n_int),
      .start (start[b]),
      .busy  (busy[b]),
      .done  (done[b]),
      .addr  (fill_addr)
    );

    ramfill_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
      .fill_busy (busy[b]),
      .fill_addr (fill_addr),
      .test_en   (test_en[b]),
      .req       (acc_req[b]),
      .req_addr  (acc_addr[b*ADDR_W +: ADDR_W]),
      .req_data  (acc_wdata[b*DATA_W +: DATA_W]),
      .req_check (acc_wcheck[b]),
      .stall     (acc_stall[b]),
      .we        (ram_we[b]),
      .addr      (ram_addr[b*ADDR_W +: ADDR_W]),
      .data      (ram_data[b*DATA_W +: DATA_W]),
      .check     (ram_check[b])
    );
  end
endmodule

// File: rtl/ramfill_ctrl_chk.sv
module ramfill_ctrl_chk #(
  parameter int NUM_BANKS = 4,
  parameter int DEPTH     = 64,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = $clog2(DEPTH)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [31:0]                 reg_rdata,
  input logic [NUM_BANKS-1:0]        acc_req,
  input logic [NUM_BANKS*ADDR_W-1:0] acc_addr,
  input logic [NUM_BANKS*DATA_W-1:0] acc_wdata,
  input logic [NUM_BANKS-1:0]        acc_wcheck,
  input logic [NUM_BANKS-1:0]        acc_stall,
  input logic [NUM_BANKS-1:0]        ram_we,
  input logic [NUM_BANKS*ADDR_W-1:0] ram_addr,
  input logic [NUM_BANKS*DATA_W-1:0] ram_data,
  input logic [NUM_BANKS-1:0]        ram_check,
  input logic [NUM_BANKS-1:0]        busy,
  input logic [NUM_BANKS-1:0]        done
);
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[31:2*NUM_BANKS] == '0);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    logic [ADDR_W:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       run_q <= '0;
      else if (busy[b]) run_q <= run_q + 1'b1;
      else              run_q <= '0;
    end

    a_r4_trigger_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[2*b] == 1'b0);

    a_r5_fill_word: assert property (@(posedge clk) disable iff (!rst_n)
      busy[b] |-> (ram_we[b] && ram_data[b*DATA_W +: DATA_W] == '0
                   && ram_check[b] == ^ram_addr[b*ADDR_W +: ADDR_W]));

    a_r5_fill_ascends: assert property (@(posedge clk) disable iff (!rst_n)
      (busy[b] && $past(busy[b])) |->
        ram_addr[b*ADDR_W +: ADDR_W] == $past(ram_addr[b*ADDR_W +: ADDR_W]) + 1'b1);

    a_r6_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy[b]) |-> run_q == (ADDR_W+1)'(DEPTH));

    a_r6_done_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done[b] |-> (!busy[b] && $past(busy[b])));

    a_r9_normal_check: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy[b] && acc_req[b] && !reg_rdata[2*b+1]) |->
        (ram_we[b] && ram_check[b] == (^acc_wdata[b*DATA_W +: DATA_W]
                                       ^ ^acc_addr[b*ADDR_W +: ADDR_W])));

    a_r10_raw_check: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy[b] && acc_req[b] && reg_rdata[2*b+1]) |-> ram_check[b] == acc_wcheck[b]);

    a_r11_stall: assert property (@(posedge clk) disable iff (!rst_n)
      acc_stall[b] == (acc_req[b] && busy[b]));
  end
endmodule

bind ramfill_ctrl ramfill_ctrl_chk #(
  .NUM_BANKS(NUM_BANKS), .DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/ramfill_ctrl_test.sv
`timescale 1ns/1ps
module ramfill_ctrl_test;
  localparam int NB = 4;
  localparam int DP = 16;
  localparam int DW = 32;
  localparam int AW = $clog2(DP);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              reg_wr;
  logic [31:0]       reg_wdata;
  logic [31:0]       reg_rdata;
  logic [NB-1:0]     acc_req;
  logic [NB*AW-1:0]  acc_addr;
  logic [NB*DW-1:0]  acc_wdata;
  logic [NB-1:0]     acc_wcheck;
  logic [NB-1:0]     acc_stall, ram_we, ram_check, busy, done;
  logic [NB*AW-1:0]  ram_addr;
  logic [NB*DW-1:0]  ram_data;

  int total = 0;
  int bad   = 0;

  // behavioural reference state
  bit m_busy [NB];
  bit m_done [NB];
  int m_cnt  [NB];
  bit m_test [NB];

  always #4 clk = ~clk;

  ramfill_ctrl #(.NUM_BANKS(NB), .DEPTH(DP), .DATA_W(DW)) uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit par(input logic [31:0] v);
    return ^v;
  endfunction

  task automatic compare();
    logic [31:0] exp_rd;
    exp_rd = '0;
    for (int b = 0; b < NB; b++) exp_rd[2*b+1] = m_test[b];
    chk("R2 R3 R4 control word", reg_rdata, exp_rd);
    for (int b = 0; b < NB; b++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      a = acc_addr[b*AW +: AW];
      d = acc_wdata[b*DW +: DW];
      chk("R6 busy", 32'(busy[b]), 32'(m_busy[b]));
      chk("R6 done", 32'(done[b]), 32'(m_done[b]));
      chk("R11 stall", 32'(acc_stall[b]), 32'(acc_req[b] & m_busy[b]));
      if (m_busy[b]) begin
        chk("R11 fill owns port we", 32'(ram_we[b]), 32'd1);
        chk("R5 fill addr", 32'(ram_addr[b*AW +: AW]), 32'(m_cnt[b]));
        chk("R5 fill data", ram_data[b*DW +: DW], 32'd0);
        chk("R5 fill check", 32'(ram_check[b]), 32'(par(32'(m_cnt[b]))));
      end else begin
        chk("R9 we", 32'(ram_we[b]), 32'(acc_req[b]));
        if (acc_req[b]) begin
          chk("R9 addr", 32'(ram_addr[b*AW +: AW]), 32'(a));
          chk("R9 data", ram_data[b*DW +: DW], d);
          if (m_test[b]) chk("R10 raw check", 32'(ram_check[b]), 32'(acc_wcheck[b]));
          else           chk("R9 check", 32'(ram_check[b]), 32'(par(d) ^ par(32'(a))));
        end
      end
    end
  endtask

  task automatic update();
    for (int b = 0; b < NB; b++) begin
      m_done[b] = 0;
      if (m_busy[b]) begin
        if (m_cnt[b] == DP-1) begin m_busy[b] = 0; m_done[b] = 1; m_cnt[b] = 0; end
        else m_cnt[b]++;
      end else if (reg_wr && reg_wdata[2*b]) begin
        m_busy[b] = 1;
        m_cnt[b]  = 0;
      end
      if (reg_wr) m_test[b] = reg_wdata[2*b+1];
    end
  endtask

  // called right after a falling edge with inputs already set
  task automatic step();
    #2;
    compare();
    @(posedge clk);
    update();
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rand_acc();
    acc_req    = NB'($urandom);
    acc_wcheck = NB'($urandom);
    for (int b = 0; b < NB; b++) begin
      acc_addr[b*AW +: AW]  = AW'($urandom);
      acc_wdata[b*DW +: DW] = $urandom;
    end
  endtask

  task automatic write_ctrl(input logic [31:0] v);
    reg_wr    = 1'b1;
    reg_wdata = v;
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 20000) begin
        bad++;
        total++;
        $display("FAIL watchdog expired R1 actual=%0d expected<=%0d", wd, 20000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    reg_wr = 1'b0;
    reg_wdata = '0;
    acc_req = '0;
    acc_addr = '0;
    acc_wdata = '0;
    acc_wcheck = '0;
    for (int b = 0; b < NB; b++) begin
      m_busy[b] = 0; m_done[b] = 0; m_cnt[b] = 0; m_test[b] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);

    // R1 reset state
    #2;
    chk("R1 control word after reset", reg_rdata, 32'd0);
    chk("R1 busy after reset", 32'(busy), 32'd0);
    chk("R1 done after reset", 32'(done), 32'd0);
    chk("R1 write enables after reset", 32'(ram_we), 32'd0);
    @(negedge clk);

    // R2 R3: reserved bits and test bits, no triggers
    write_ctrl(32'hFFFF_FF00 | 32'h0000_000A);
    step();
    chk("R2 R3 readback", reg_rdata, 32'h0000_000A);

    // R9 R10 normal traffic with mixed test modes
    for (int i = 0; i < 20; i++) begin rand_acc(); step(); end

    // R5 R8 start banks 0 and 2 together, test bits kept
    rand_acc();
    write_ctrl(32'h0000_001B);
    step();
    chk("R4 trigger bits read zero", reg_rdata & 32'h55, 32'd0);
    chk("R8 two banks busy together", 32'(busy), 32'b0101);
    for (int i = 0; i < 6; i++) begin rand_acc(); step(); end

    // R7 retrigger bank 0 while busy, also start bank 1 (R8)
    rand_acc();
    write_ctrl(32'h0000_000F);
    step();
    chk("R7 retrigger keeps address", 32'(ram_addr[0 +: AW]), 32'(m_cnt[0]));
    chk("R7 retrigger no restart", 32'(ram_addr[0 +: AW] != '0), 32'd1);
    chk("R8 bank 1 busy with 0 and 2", 32'(busy), 32'b0111);
    for (int i = 0; i < 30; i++) begin rand_acc(); step(); end

    // R5 zero trigger does nothing
    acc_req = '0;
    write_ctrl(32'h0000_0000);
    step();
    chk("R5 zero write starts nothing", 32'(busy), 32'd0);
    for (int i = 0; i < 3; i++) begin rand_acc(); step(); end

    // all banks at once, test mode on 3
    rand_acc();
    write_ctrl(32'h0000_00D5);
    step();
    chk("R8 all banks busy", 32'(busy), 32'b1111);
    for (int i = 0; i < DP + 6; i++) begin rand_acc(); step(); end
    for (int i = 0; i < 10; i++) begin rand_acc(); step(); end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule